// File: doc/BRIEF.md
# Keyed Write-Protection Gate

This block keeps stray register writes away from a timekeeping unit's sensitive registers. These are the calendar time and date, control, status/init, prescaler and alarm registers. The gate sits on the register write path. Every write strobe, with its address and data, passes through it. A strobe that targets a guarded register is forwarded only while the gate is open.

Software opens the gate by writing two key bytes, one after the other, to a dedicated key address. The first byte is 0xCA and the second is 0x53. Any other byte written to the key address, at any step, closes the gate again. Writes to other addresses between the two key writes do not break the sequence. Writes to addresses outside the guarded set are always forwarded. Writes to the key address are never forwarded. The gate does not touch reads.

Top module: `wprot_gate`

## Requirements
- R1: After reset, and after any later reset, `unlocked` is 0.
- R2: A key write with low byte 0xCA followed by a key write with low byte 0x53 drives `unlocked` to 1 from the cycle after the second write. The key address is 0x24.
- R3: A key write of 0x53 that does not directly follow an accepted 0xCA leaves `unlocked` at 0.
- R4: If the next key write after 0xCA has any low byte other than 0x53, the gate returns to the closed state. A 0x53 after that does not open it.
- R5: While open, a key write with low byte 0xCA closes the gate and arms the second step. Any other key byte closes the gate fully. In both cases `unlocked` is 0 from the next cycle.
- R6: Only bits [7:0] of a key write are compared. The upper data bits are ignored.
- R7: A write to a guarded address (0x00, 0x04, 0x08, 0x0C, 0x10, 0x1C) while `unlocked` is 0 gives `pass_wr` = 0 in that cycle.
- R8: A write to a guarded address while `unlocked` is 1 gives `pass_wr` = 1 in the same cycle.
- R9: A write to the key address never raises `pass_wr`. A write to an address that is neither guarded nor the key address (e.g. 0x14) raises `pass_wr` in any state.
- R10: Cycles without a key write (idle cycles or writes to other addresses) do not change the key sequence state.
- R11: `pass_wr` is 0 whenever `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Write byte address |
| wr_data | input | DATA_W (32) | Write data |
| pass_wr | output | 1 | Forwarded write strobe to the register file |
| unlocked | output | 1 | Gate open; guarded registers are writable |

## Verification
A wrong internal state shows at the ports in one of two ways. If the gate opens early, or stays open after a bad key, a guarded write raises `pass_wr` in the very next cycle. If the gate fails to open, a guarded write right after the 0x53 key is dropped. `unlocked` follows the key state one cycle after each key write, so each sequence step is checked at that edge. A lost armed state appears only one key write later, which is why the vectors interleave other-address writes between the two keys and check `pass_wr` in the same cycle as each strobe.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

   typedef enum logic [1:0] {
      LK_CLOSED = 2'd0,
      LK_ARMED  = 2'd1,
      LK_OPEN   = 2'd2
   } lock_state_t;

endpackage

// File: rtl/wprot_addr_decode.sv
module wprot_addr_decode #(
   parameter int                       ADDR_W    = 8,
   parameter int                       NUM_PROT  = 6,
   parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = '0,
   parameter logic [ADDR_W-1:0]        KEY_ADDR  = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_key,
   output logic              hit_prot
);

   if (NUM_PROT < 1) begin : g_bad_count
      $error("wprot_addr_decode: NUM_PROT must be at least 1");
   end

   logic [NUM_PROT-1:0] match;

   for (genvar i = 0; i < NUM_PROT; i++) begin : g_cmp
      assign match[i] = (addr == PROT_LIST[i*ADDR_W +: ADDR_W]);
   end

   assign hit_prot = |match;
   assign hit_key  = (addr == KEY_ADDR);

endmodule

// File: rtl/wprot_keyseq.sv
module wprot_keyseq
   import wprot_pkg::*;
#(
   parameter int                 DATA_W     = 32,
   parameter int                 KEY_BITS   = 8,
   parameter logic [KEY_BITS-1:0] KEY_FIRST  = 8'hCA,
   parameter logic [KEY_BITS-1:0] KEY_SECOND = 8'h53
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   output logic              unlocked
);

   if (KEY_BITS > DATA_W) begin : g_bad_key
      $error("wprot_keyseq: KEY_BITS exceeds DATA_W");
   end
   if (KEY_FIRST == KEY_SECOND) begin : g_bad_pair
      $error("wprot_keyseq: the two keys must differ");
   end

   lock_state_t          state_q, state_d;
   logic [KEY_BITS-1:0]  key_lo;

   assign key_lo = key_data[KEY_BITS-1:0];

   always_comb begin
      state_d = state_q;
      if (key_wr) begin
         unique case (state_q)
            LK_ARMED: state_d = (key_lo == KEY_SECOND) ? LK_OPEN : LK_CLOSED;
            default:  state_d = (key_lo == KEY_FIRST)  ? LK_ARMED : LK_CLOSED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LK_CLOSED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == LK_OPEN);

   AST_OPEN_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && key_lo == KEY_SECOND)); // R2

   AST_STRAY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && state_q != LK_ARMED) |=> !unlocked); // R3

   AST_OPEN_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && unlocked) |=> !unlocked); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !key_wr |=> (state_q == $past(state_q))); // R10

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
   parameter int                         ADDR_W     = 8,
   parameter int                         DATA_W     = 32,
   parameter int                         KEY_BITS   = 8,
   parameter logic [ADDR_W-1:0]          KEY_ADDR   = 8'h24,
   parameter logic [KEY_BITS-1:0]        KEY_FIRST  = 8'hCA,
   parameter logic [KEY_BITS-1:0]        KEY_SECOND = 8'h53,
   parameter int                         NUM_PROT   = 6,
   parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST  =
      {8'h1C, 8'h10, 8'h0C, 8'h08, 8'h04, 8'h00}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pass_wr,
   output logic              unlocked
);

   logic hit_key, hit_prot, key_wr;

   wprot_addr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_PROT  (NUM_PROT),
      .PROT_LIST (PROT_LIST),
      .KEY_ADDR  (KEY_ADDR)
   ) u_dec (
      .addr     (wr_addr),
      .hit_key  (hit_key),
      .hit_prot (hit_prot)
   );

   assign key_wr = wr_en & hit_key;

   wprot_keyseq #(
      .DATA_W     (DATA_W),
      .KEY_BITS   (KEY_BITS),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (wr_data),
      .unlocked (unlocked)
   );

   always_comb begin
      if (!wr_en || hit_key) pass_wr = 1'b0;
      else if (hit_prot)     pass_wr = unlocked;
      else                   pass_wr = 1'b1;
   end

   AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_prot && !unlocked) |-> !pass_wr); // R7

   AST_KEY_SWALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_key) |-> !pass_wr); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !pass_wr); // R11

endmodule

// File: tb/tb_wprot_gate.sv
module tb_wprot_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pass_wr, unlocked;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   wprot_gate dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pass_wr(pass_wr), .unlocked(unlocked)
   );

   // {req[3:0], en, addr[7:0], data[31:0], exp_pass, exp_unlocked_after}
   localparam int NV = 21;
   localparam logic [46:0] VEC [NV] = '{
      {4'd11, 1'b0, 8'h00, 32'h0000_0000, 1'b0, 1'b0}, // R11 idle
      {4'd7,  1'b1, 8'h00, 32'h0000_0005, 1'b0, 1'b0}, // R7 locked drop
      {4'd3,  1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b0}, // R3 stray second key
      {4'd4,  1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b0}, // R4 arm
      {4'd4,  1'b1, 8'h24, 32'h0000_0011, 1'b0, 1'b0}, // R4 wrong byte
      {4'd4,  1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b0}, // R4 no open
      {4'd10, 1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b0}, // R10 arm
      {4'd9,  1'b1, 8'h14, 32'h0000_0000, 1'b1, 1'b0}, // R9 other addr forwarded
      {4'd10, 1'b1, 8'h00, 32'h0000_0001, 1'b0, 1'b0}, // R10 guarded write while armed
      {4'd2,  1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b1}, // R2 open
      {4'd8,  1'b1, 8'h08, 32'h0000_0040, 1'b1, 1'b1}, // R8
      {4'd8,  1'b1, 8'h1C, 32'h1234_5678, 1'b1, 1'b1}, // R8
      {4'd11, 1'b0, 8'h1C, 32'h0000_0000, 1'b0, 1'b1}, // R11
      {4'd5,  1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b0}, // R5 relock armed
      {4'd5,  1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b1}, // R5 reopen
      {4'd5,  1'b1, 8'h24, 32'h0000_00FF, 1'b0, 1'b0}, // R5 relock
      {4'd7,  1'b1, 8'h10, 32'h0000_7FFF, 1'b0, 1'b0}, // R7
      {4'd6,  1'b1, 8'h24, 32'hFFFF_FFCA, 1'b0, 1'b0}, // R6 upper bits ignored
      {4'd6,  1'b1, 8'h24, 32'h1234_5653, 1'b0, 1'b1}, // R6
      {4'd8,  1'b1, 8'h0C, 32'h0000_0080, 1'b1, 1'b1}, // R8
      {4'd6,  1'b1, 8'h24, 32'h0000_CA00, 1'b0, 1'b0}  // R6 low byte 00 locks
   };

   task automatic check(input int req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1, "unlocked in reset", unlocked, 1'b0); // R1
      rst_n = 1'b1;
      @(negedge clk);
      check(1, "unlocked after reset", unlocked, 1'b0); // R1

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         wr_en   = VEC[i][42];
         wr_addr = VEC[i][41:34];
         wr_data = VEC[i][33:2];
         #1;
         check(int'(VEC[i][46:43]), "pass_wr", pass_wr, VEC[i][1]);
         @(posedge clk);
         #1;
         check(int'(VEC[i][46:43]), "unlocked", unlocked, VEC[i][0]);
      end
      @(negedge clk);
      wr_en = 1'b0;

      // R1: reset while open closes the gate
      wr(8'h24, 32'hCA);
      wr(8'h24, 32'h53);
      check(2, "open before reset", unlocked, 1'b1); // R2
      rst_n = 1'b0;
      #1;
      check(1, "unlocked during reset", unlocked, 1'b0); // R1
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, "unlocked after mid reset", unlocked, 1'b0); // R1
      wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h1;
      #1;
      check(7, "date write after reset", pass_wr, 1'b0); // R7
      @(negedge clk);
      wr_en = 1'b0;

      // R10: idle cycles between keys keep the armed state
      wr(8'h24, 32'hCA);
      repeat (4) @(negedge clk);
      wr(8'h24, 32'h53);
      check(10, "open after idle gap", unlocked, 1'b1); // R10

      // R9: key address write never forwarded even when open
      wr_en = 1'b1; wr_addr = 8'h24; wr_data = 32'h53;
      #1;
      check(9, "key write forwarded", pass_wr, 1'b0); // R9
      @(negedge clk);
      wr_en = 1'b0;
      check(5, "relock on repeated second key", unlocked, 1'b0); // R5

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule